// File: doc/BRIEF.md
# Console Character Port Command Controller

This block is the register and control logic of a console character port that sits on a programmed-I/O bus. Each bus command carries a class, a 4-bit function code and a 16-bit accumulator value. The class is one of control, skip test, input or output. One cycle after a command, the block returns an updated accumulator and a skip flag. A set skip flag means the test held or the transfer succeeded.

The port holds one received byte from a valid/ready receive stream. It also holds one outgoing character for a valid/ready transmit stream. Alongside these it keeps the following state:
- the port mode (receive-only or transmit-only)
- a receive and a transmit interrupt mask
- a receive and a transmit DMA enable
- two control registers per direction
- parity-error, framing-error and overrun flags

The interrupt request lines are driven from the masks and the buffer state. Line timing, serialization and real DMA transfers happen outside the block.

Top module: `console_port_ctrl`

## Requirements
- R1: After a synchronous reset, the following hold: the mode is receive-only, both masks and both DMA enables are clear, no received character is held, `tx_valid` is low, both interrupt lines are low, and `rsp_valid` is low.
- R2: Control function 0 selects receive-only mode and control function 1 selects transmit-only mode. Control function 17 (octal) selects receive-only mode and also clears both masks and both DMA enables.
- R3: The control functions act on the masks and DMA enables as follows (octal codes):
  - 2 sets the receive mask.
  - 5 sets the transmit mask.
  - 3 sets the receive DMA enable.
  - 6 sets the transmit DMA enable.
  - 4 clears the receive mask and the receive DMA enable.
  - 7 clears the transmit mask and the transmit DMA enable.
  - 15 sets both masks.
  - 16 clears both masks.
- R4: For every command, `rsp_valid` is high exactly one cycle after `cmd_valid`. Control commands never set `rsp_skip`, and they return A unchanged. Class encoding: 0 control, 1 skip test, 2 input, 3 output.
- R5: The skip tests return A unchanged and behave as follows:
  - 6 skips when the transmitter holds no character.
  - 7 skips when a received character is waiting.
  - 4 skips when neither interrupt line is active.
- R6: Skip tests 15, 16 and 17 (octal) skip on a stored parity error, overrun and framing error respectively.
- R7: Input function 0 ORs the waiting character into A[7:0] and keeps A[15:8]. Input function 10 (octal) returns the character zero-extended. Both skip only when a character is waiting; with no character waiting, A is returned unchanged with no skip. A successful read empties the buffer and clears all three error flags.
- R8: Input function 11 (octal) returns the device identifier 4 and skips.
- R9: Output functions 4 to 7 write the receive control registers 1 and 2 and the transmit control registers 1 and 2. Input functions 4 to 7 read the same registers back. Both always skip, and all four registers reset to 0.
- R10: Output function 0 puts `{0, A[6:0]}` on `tx_data` with `tx_valid` high until `tx_ready`, and skips. It fails with no skip in receive-only mode or while a character is still held.
- R11: An output-0 character whose low 7 bits are 0 or 177 (octal) skips but is not sent.
- R12: A byte that arrives while the previous byte is unread replaces it and sets the overrun flag.
- R13: `irq_rx` equals the receive mask AND character-waiting. `irq_tx` equals the transmit mask AND transmitter-empty.
- R14: Any function not listed above returns A unchanged with no skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_class | input | 2 | 0 control, 1 skip test, 2 input, 3 output |
| cmd_func | input | 4 | Function code |
| cmd_a | input | 16 | Accumulator value in |
| rsp_valid | output | 1 | Response present |
| rsp_a | output | 16 | Accumulator value out |
| rsp_skip | output | 1 | Skip / success flag |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive stream accepted (always high) |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error for the offered byte |
| rx_ferr | input | 1 | Framing error for the offered byte |
| tx_valid | output | 1 | Outgoing character held |
| tx_ready | input | 1 | Transmit stream takes the character |
| tx_data | output | 8 | Outgoing character |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| rx_dma_en | output | 1 | Receive DMA enable |
| tx_dma_en | output | 1 | Transmit DMA enable |

## Verification
A table of command vectors drives every class through defined and undefined function codes in both modes. This separates "always succeeds" functions from mode-refused ones and from silently ignored codes. Directed sequences then feed receive bytes in different patterns and check the data path and error flags:
- a lone byte, read with the OR variant and with the clear variant
- two bytes back to back with no read between them, which is the only pattern that exposes overrun
- bytes tagged with parity or framing errors, each checked against its own skip test

The transmit path is tried with printable and null characters, and with a second send while the first is still held. Mask and DMA codes are applied one at a time, with the interrupt lines observed after each, so that a code touching the wrong direction shows up.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  typedef enum logic [1:0] {
    CLS_CTL  = 2'd0,
    CLS_SKIP = 2'd1,
    CLS_IN   = 2'd2,
    CLS_OUT  = 2'd3
  } cls_e;

  typedef enum logic {
    MODE_RX_ONLY = 1'b0,
    MODE_TX_ONLY = 1'b1
  } mode_e;

  localparam logic [3:0] FN_0  = 4'o00;
  localparam logic [3:0] FN_1  = 4'o01;
  localparam logic [3:0] FN_2  = 4'o02;
  localparam logic [3:0] FN_3  = 4'o03;
  localparam logic [3:0] FN_4  = 4'o04;
  localparam logic [3:0] FN_5  = 4'o05;
  localparam logic [3:0] FN_6  = 4'o06;
  localparam logic [3:0] FN_7  = 4'o07;
  localparam logic [3:0] FN_10 = 4'o10;
  localparam logic [3:0] FN_11 = 4'o11;
  localparam logic [3:0] FN_15 = 4'o15;
  localparam logic [3:0] FN_16 = 4'o16;
  localparam logic [3:0] FN_17 = 4'o17;
endpackage

// File: rtl/cpc_rx_hold.sv
module cpc_rx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_perr,
  input  logic              in_ferr,
  input  logic              take,
  output logic              full,
  output logic [BYTE_W-1:0] data,
  output logic              perr,
  output logic              ferr,
  output logic              ovr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
      ovr  <= 1'b0;
    end else if (in_valid) begin
      full <= 1'b1;
      data <= in_data;
      perr <= in_perr;
      ferr <= in_ferr;
      ovr  <= full && !take;
    end else if (take) begin
      full <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
      ovr  <= 1'b0;
    end
  end

  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (rst)
    in_valid && full && !take |=> ovr); // R12
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    take && !in_valid |=> !full && !ovr && !perr && !ferr); // R7
endmodule

// File: rtl/cpc_tx_hold.sv
module cpc_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              busy,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      out_data <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      out_data <= load_data;
    end else if (out_ready) begin
      busy <= 1'b0;
    end
  end

  AST_TX_HELD: assert property (@(posedge clk) disable iff (rst)
    busy && !out_ready |=> busy && $stable(out_data)); // R10
endmodule

// File: rtl/console_port_ctrl.sv
module console_port_ctrl
  import cpc_pkg::*;
#(
  parameter int A_W    = 16,
  parameter int BYTE_W = 8,
  parameter int CHAR_W = 7,
  parameter int DEV_ID = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_class,
  input  logic [3:0]        cmd_func,
  input  logic [A_W-1:0]    cmd_a,
  output logic              rsp_valid,
  output logic [A_W-1:0]    rsp_a,
  output logic              rsp_skip,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_perr,
  input  logic              rx_ferr,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              rx_dma_en,
  output logic              tx_dma_en
);
  localparam int NUM_CREG = 4;
  localparam int CIDX_W   = $clog2(NUM_CREG);
  localparam logic [A_W-1:0]    ID_VAL   = A_W'(DEV_ID);
  localparam logic [CHAR_W-1:0] CH_NULL  = '0;
  localparam logic [CHAR_W-1:0] CH_RUB   = '1;

  cls_e  cls;
  mode_e mode;
  logic  rx_mask, tx_mask;
  logic  rx_full, rx_pe, rx_fe, rx_ov, tx_busy;
  logic [BYTE_W-1:0] rx_char;
  logic [A_W-1:0] creg [NUM_CREG];
  logic [A_W-1:0] nxt_a;
  logic nxt_skip, rd_char, send, creg_we;
  logic [CHAR_W-1:0] out_ch;

  assign cls      = cls_e'(cmd_class);
  assign out_ch   = cmd_a[CHAR_W-1:0];
  assign rx_ready = 1'b1;
  assign tx_valid = tx_busy;
  assign irq_rx   = rx_mask && rx_full;
  assign irq_tx   = tx_mask && !tx_busy;

  cpc_rx_hold #(.BYTE_W(BYTE_W)) i_rx (
    .clk(clk), .rst(rst), .in_valid(rx_valid), .in_data(rx_data),
    .in_perr(rx_perr), .in_ferr(rx_ferr), .take(rd_char),
    .full(rx_full), .data(rx_char), .perr(rx_pe), .ferr(rx_fe), .ovr(rx_ov)
  );

  cpc_tx_hold #(.BYTE_W(BYTE_W)) i_tx (
    .clk(clk), .rst(rst), .load(send),
    .load_data({{(BYTE_W-CHAR_W){1'b0}}, out_ch}),
    .busy(tx_busy), .out_data(tx_data), .out_ready(tx_ready)
  );

  // command decode
  always_comb begin
    nxt_a    = cmd_a;
    nxt_skip = 1'b0;
    rd_char  = 1'b0;
    send     = 1'b0;
    creg_we  = 1'b0;
    if (cmd_valid) begin
      unique case (cls)
        CLS_SKIP: begin
          case (cmd_func)
            FN_4:    nxt_skip = !irq_rx && !irq_tx;
            FN_6:    nxt_skip = !tx_busy;
            FN_7:    nxt_skip = rx_full;
            FN_15:   nxt_skip = rx_pe;
            FN_16:   nxt_skip = rx_ov;
            FN_17:   nxt_skip = rx_fe;
            default: nxt_skip = 1'b0;
          endcase
        end
        CLS_IN: begin
          if (cmd_func == FN_0 || cmd_func == FN_10) begin
            if (rx_full) begin
              rd_char  = 1'b1;
              nxt_skip = 1'b1;
              if (cmd_func == FN_10)
                nxt_a = {{(A_W-BYTE_W){1'b0}}, rx_char};
              else
                nxt_a = {cmd_a[A_W-1:BYTE_W], cmd_a[BYTE_W-1:0] | rx_char};
            end
          end else if (cmd_func[3:2] == 2'b01) begin
            nxt_a    = creg[cmd_func[CIDX_W-1:0]];
            nxt_skip = 1'b1;
          end else if (cmd_func == FN_11) begin
            nxt_a    = ID_VAL;
            nxt_skip = 1'b1;
          end
        end
        CLS_OUT: begin
          if (cmd_func == FN_0) begin
            if (mode == MODE_TX_ONLY && !tx_busy) begin
              nxt_skip = 1'b1;
              send     = (out_ch != CH_NULL) && (out_ch != CH_RUB);
            end
          end else if (cmd_func[3:2] == 2'b01) begin
            creg_we  = 1'b1;
            nxt_skip = 1'b1;
          end
        end
        default: nxt_skip = 1'b0;
      endcase
    end
  end

  // mode, masks, DMA enables
  always_ff @(posedge clk) begin
    if (rst) begin
      mode      <= MODE_RX_ONLY;
      rx_mask   <= 1'b0;
      tx_mask   <= 1'b0;
      rx_dma_en <= 1'b0;
      tx_dma_en <= 1'b0;
    end else if (cmd_valid && cls == CLS_CTL) begin
      case (cmd_func)
        FN_0: mode <= MODE_RX_ONLY;
        FN_1: mode <= MODE_TX_ONLY;
        FN_2: rx_mask <= 1'b1;
        FN_3: rx_dma_en <= 1'b1;
        FN_4: begin rx_mask <= 1'b0; rx_dma_en <= 1'b0; end
        FN_5: tx_mask <= 1'b1;
        FN_6: tx_dma_en <= 1'b1;
        FN_7: begin tx_mask <= 1'b0; tx_dma_en <= 1'b0; end
        FN_15: begin rx_mask <= 1'b1; tx_mask <= 1'b1; end
        FN_16: begin rx_mask <= 1'b0; tx_mask <= 1'b0; end
        FN_17: begin
          mode      <= MODE_RX_ONLY;
          rx_mask   <= 1'b0;
          tx_mask   <= 1'b0;
          rx_dma_en <= 1'b0;
          tx_dma_en <= 1'b0;
        end
        default: mode <= mode;
      endcase
    end
  end

  // control registers, one per function 4..7
  for (genvar g = 0; g < NUM_CREG; g++) begin : g_creg
    always_ff @(posedge clk) begin
      if (rst)
        creg[g] <= '0;
      else if (creg_we && cmd_func[CIDX_W-1:0] == CIDX_W'(g))
        creg[g] <= cmd_a;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_a     <= '0;
      rsp_skip  <= 1'b0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_a     <= nxt_a;
      rsp_skip  <= nxt_skip;
    end
  end

  AST_CTL_NEVER_SKIPS: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_class == 2'd0 |=> rsp_valid && !rsp_skip); // R4
  AST_RXONLY_REFUSES: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_class == 2'd3 && cmd_func == 4'd0 && mode == MODE_RX_ONLY
    |=> !rsp_skip && !tx_valid); // R10
  AST_NULL_UNSENT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_class == 2'd3 && cmd_func == 4'd0 && !tx_valid &&
    (cmd_a[CHAR_W-1:0] == CH_NULL || cmd_a[CHAR_W-1:0] == CH_RUB)
    |=> !tx_valid); // R11
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_class == 2'd2 && cmd_func == 4'o11
    |=> rsp_skip && rsp_a == ID_VAL); // R8
endmodule

// File: tb/test_console_port_ctrl.sv
module test_console_port_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_class = '0;
  logic [3:0]  cmd_func = '0;
  logic [15:0] cmd_a = '0;
  logic        rsp_valid, rsp_skip, rx_ready, tx_valid;
  logic [15:0] rsp_a;
  logic        rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_data = '0, tx_data;
  logic        irq_rx, irq_tx, rx_dma_en, tx_dma_en;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  console_port_ctrl i_console_port_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
    .cmd_func(cmd_func), .cmd_a(cmd_a), .rsp_valid(rsp_valid), .rsp_a(rsp_a),
    .rsp_skip(rsp_skip), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en)
  );

  // {class, func, a_in, a_expected, skip_expected, req}
  localparam int NV = 23;
  localparam logic [42:0] VEC [NV] = '{
    {2'd1, 4'o06, 16'h0000, 16'h0000, 1'b1, 4'd5},   // R5 tx empty
    {2'd1, 4'o07, 16'h0101, 16'h0101, 1'b0, 4'd5},   // R5 nothing received
    {2'd1, 4'o04, 16'h0000, 16'h0000, 1'b1, 4'd5},   // R5 no interrupt
    {2'd3, 4'o00, 16'h0041, 16'h0041, 1'b0, 4'd10},  // R10 refused in rx-only
    {2'd0, 4'o01, 16'h0007, 16'h0007, 1'b0, 4'd4},   // R4 control, no skip
    {2'd3, 4'o04, 16'h1234, 16'h1234, 1'b1, 4'd9},   // R9
    {2'd3, 4'o07, 16'hBEEF, 16'hBEEF, 1'b1, 4'd9},   // R9
    {2'd2, 4'o04, 16'hFFFF, 16'h1234, 1'b1, 4'd9},   // R9
    {2'd2, 4'o07, 16'h0000, 16'hBEEF, 1'b1, 4'd9},   // R9
    {2'd2, 4'o05, 16'h5A5A, 16'h0000, 1'b1, 4'd9},   // R9 reset value
    {2'd2, 4'o11, 16'h1200, 16'h0004, 1'b1, 4'd8},   // R8
    {2'd2, 4'o00, 16'hAB00, 16'hAB00, 1'b0, 4'd7},   // R7 empty
    {2'd2, 4'o10, 16'hAB00, 16'hAB00, 1'b0, 4'd7},   // R7 empty
    {2'd3, 4'o00, 16'h0000, 16'h0000, 1'b1, 4'd11},  // R11 null
    {2'd3, 4'o00, 16'h00FF, 16'h00FF, 1'b1, 4'd11},  // R11 rubout
    {2'd0, 4'o05, 16'h0000, 16'h0000, 1'b0, 4'd4},   // R4
    {2'd1, 4'o04, 16'h0000, 16'h0000, 1'b0, 4'd13},  // R13 tx interrupting
    {2'd0, 4'o16, 16'h0000, 16'h0000, 1'b0, 4'd3},   // R3
    {2'd1, 4'o04, 16'h0000, 16'h0000, 1'b1, 4'd3},   // R3
    {2'd2, 4'o03, 16'h5555, 16'h5555, 1'b0, 4'd14},  // R14
    {2'd3, 4'o02, 16'h5555, 16'h5555, 1'b0, 4'd14},  // R14
    {2'd1, 4'o01, 16'h0000, 16'h0000, 1'b0, 4'd14},  // R14
    {2'd1, 4'o15, 16'h0000, 16'h0000, 1'b0, 4'd6}    // R6 no parity error
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] c, input logic [3:0] f, input logic [15:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_class = c; cmd_func = f; cmd_a = a;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_perr = pe; rx_ferr = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk("R1 tx_valid", {15'd0, tx_valid}, 16'd0);
    chk("R1 irqs", {14'd0, irq_rx, irq_tx}, 16'd0);
    chk("R1 dma", {14'd0, rx_dma_en, tx_dma_en}, 16'd0);
    chk("R1 rx_ready", {15'd0, rx_ready}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      cmd(v[42:41], v[40:37], v[36:21]);
      chk($sformatf("R%0d row %0d a", v[3:0], i), rsp_a, v[20:5]);
      chk($sformatf("R%0d row %0d skip", v[3:0], i), {15'd0, rsp_skip}, {15'd0, v[4]});
      chk($sformatf("R4 row %0d valid", i), {15'd0, rsp_valid}, 16'd1);
    end
    @(negedge clk);
    chk("R4 valid one cycle", {15'd0, rsp_valid}, 16'd0);
    chk("R11 nothing sent", {15'd0, tx_valid}, 16'd0);

    // R10 transmit path
    cmd(2'd3, 4'o00, 16'hFFC1);
    chk("R10 send skip", {15'd0, rsp_skip}, 16'd1);
    chk("R10 tx_valid", {15'd0, tx_valid}, 16'd1);
    chk("R10 tx_data", {8'd0, tx_data}, 16'h0041);
    cmd(2'd1, 4'o06, 16'h0000);
    chk("R5 tx busy", {15'd0, rsp_skip}, 16'd0);
    cmd(2'd3, 4'o00, 16'h0042);
    chk("R10 busy refuse", {15'd0, rsp_skip}, 16'd0);
    chk("R10 data held", {8'd0, tx_data}, 16'h0041);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R10 drained", {15'd0, tx_valid}, 16'd0);

    // R13 transmit mask
    cmd(2'd0, 4'o05, 16'h0000);
    chk("R13 irq_tx on", {15'd0, irq_tx}, 16'd1);
    cmd(2'd0, 4'o07, 16'h0000);
    chk("R3 irq_tx off by 7", {15'd0, irq_tx}, 16'd0);

    // R7 receive path with OR read
    push(8'h5A, 1'b0, 1'b0);
    cmd(2'd1, 4'o07, 16'h0000);
    chk("R5 char waiting", {15'd0, rsp_skip}, 16'd1);
    chk("R13 irq_rx masked off", {15'd0, irq_rx}, 16'd0);
    cmd(2'd0, 4'o02, 16'h0000);
    chk("R13 irq_rx on", {15'd0, irq_rx}, 16'd1);
    cmd(2'd2, 4'o00, 16'h1280);
    chk("R7 or read", rsp_a, 16'h12DA);
    chk("R7 or skip", {15'd0, rsp_skip}, 16'd1);
    chk("R13 irq_rx after read", {15'd0, irq_rx}, 16'd0);
    cmd(2'd1, 4'o07, 16'h0000);
    chk("R7 buffer empty", {15'd0, rsp_skip}, 16'd0);
    cmd(2'd0, 4'o04, 16'h0000);

    // R7 clear-first read
    push(8'h33, 1'b0, 1'b0);
    cmd(2'd2, 4'o10, 16'hFFFF);
    chk("R7 clear read", rsp_a, 16'h0033);

    // R12 overrun
    push(8'h11, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b0);
    cmd(2'd1, 4'o16, 16'h0000);
    chk("R12 overrun skip", {15'd0, rsp_skip}, 16'd1);
    cmd(2'd2, 4'o10, 16'h0000);
    chk("R12 newest kept", rsp_a, 16'h0022);
    cmd(2'd1, 4'o16, 16'h0000);
    chk("R12 cleared by read", {15'd0, rsp_skip}, 16'd0);

    // R6 parity / framing
    push(8'h44, 1'b1, 1'b0);
    cmd(2'd1, 4'o15, 16'h0000);
    chk("R6 parity", {15'd0, rsp_skip}, 16'd1);
    cmd(2'd1, 4'o17, 16'h0000);
    chk("R6 no framing", {15'd0, rsp_skip}, 16'd0);
    cmd(2'd2, 4'o10, 16'h0000);
    push(8'h45, 1'b0, 1'b1);
    cmd(2'd1, 4'o17, 16'h0000);
    chk("R6 framing", {15'd0, rsp_skip}, 16'd1);
    cmd(2'd1, 4'o15, 16'h0000);
    chk("R6 no parity", {15'd0, rsp_skip}, 16'd0);
    cmd(2'd2, 4'o10, 16'h0000);
    cmd(2'd1, 4'o17, 16'h0000);
    chk("R7 flags cleared", {15'd0, rsp_skip}, 16'd0);

    // R3 DMA enables and both-mask codes
    cmd(2'd0, 4'o03, 16'h0000);
    cmd(2'd0, 4'o06, 16'h0000);
    chk("R3 dma set", {14'd0, rx_dma_en, tx_dma_en}, 16'd3);
    cmd(2'd0, 4'o04, 16'h0000);
    chk("R3 rx dma cleared", {14'd0, rx_dma_en, tx_dma_en}, 16'd1);
    cmd(2'd0, 4'o15, 16'h0000);
    chk("R3 both masks", {14'd0, irq_rx, irq_tx}, 16'd1);
    push(8'h66, 1'b0, 1'b0);
    chk("R13 both irqs", {14'd0, irq_rx, irq_tx}, 16'd3);

    // R2 master clear
    cmd(2'd0, 4'o17, 16'h0000);
    chk("R2 clear irqs", {14'd0, irq_rx, irq_tx}, 16'd0);
    chk("R2 clear dma", {14'd0, rx_dma_en, tx_dma_en}, 16'd0);
    cmd(2'd3, 4'o00, 16'h0041);
    chk("R2 rx-only again", {15'd0, rsp_skip}, 16'd0);
    cmd(2'd0, 4'o00, 16'h0000);
    cmd(2'd3, 4'o00, 16'h0041);
    chk("R2 func 0 rx-only", {15'd0, tx_valid}, 16'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule